// File: doc/BRIEF.md
# Serial converter control-byte front end

This block is the digital side of a successive-approximation converter that sits behind a four-wire serial port. The port has an active-low select, a serial clock, a data input, a data output and a conversion strobe. After select falls, the block waits for a 1 bit on the data input. That 1 bit opens an 8-bit control byte. The byte picks the input channel pair, the output polarity, single-ended or differential input, and one of four power/clock modes. The block then drives the track and hold phases, runs the bit decisions and shifts the 12-bit result out MSB first.

The block does not model the analog comparator. It captures a digital level word, `sample_i`, at the hold instant and resolves it one bit per decision against the trial code built so far. In external-clock mode the serial clock paces the decisions. In internal-clock mode a divided system clock paces them. The serial pins are oversampled on the system clock. The two tri-state outputs come out as value/enable pairs.

Control byte, MSB first: start(7), pair-odd select(6), pair select(5), reserved select(4), unipolar(3), single-ended(2), mode(1:0).

Top module: `sar_serial_front`

## Requirements
- R1: After select falls, 0 bits on the data input are ignored. The first 1 bit sampled becomes bit 7 of the control byte, and the next seven bits fill bits 6 down to 0.
- R2: The data input is sampled on serial-clock rising edges. `sdo_o` changes only after a serial-clock falling edge or a select rise, and never on a rising edge.
- R3: `track_o` rises on the falling edge after control bit 5 and drops on the falling edge after control bit 8. It is never high while `strb_o` is high.
- R4: From the falling edge after control bit 6, `mux_pos_o` = {byte bit 5, byte bit 6}. If byte bit 2 = 1, then `neg_com_o` = 1 and `mux_neg_o` = 0. Otherwise `neg_com_o` = 0 and `mux_neg_o` = {byte bit 5, inverted byte bit 6}.
- R5: Mode 00 (deep sleep) and mode 01 (light sleep) set `sleep_o` on the falling edge after bit 8 and start no conversion: the strobe stays low and `sdo_o` stays 0. The rising edge that samples the next start bit clears `sleep_o`.
- R6: Mode 11 (external clock): `strb_o` is high from the falling edge after bit 8 until the next falling edge. The next 12 falling edges present result bits 11 down to 0 on `sdo_o`, and later falling edges drive 0.
- R7: If byte bit 3 = 1, the result equals `sample_i` captured at the hold edge (straight binary). If bit 3 = 0, the result is `sample_i` with its MSB inverted (two's complement).
- R8: Mode 10 (internal clock): `strb_o` goes low at the hold edge and stays low for RES_W*CYC_PER_BIT system cycles, then goes high. The first falling edge after that presents the result MSB, and the next 11 falling edges present the rest. A select rise during the conversion does not abort it.
- R9: While select is high, `sdo_oe_o` is 0, and `strb_oe_o` is 0 except during or after an internal-clock conversion. After select falls, the strobe is driven low.
- R10: A select rise while a control byte is being received, or during an external-clock readout, abandons the frame and clears `track_o`. The next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sample_i | input | RES_W | Digital stand-in for the held analog level |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable |
| strb_o | output | 1 | Conversion strobe value |
| strb_oe_o | output | 1 | Strobe enable |
| track_o | output | 1 | Track phase active |
| mux_pos_o | output | 2 | Positive input channel index |
| mux_neg_o | output | 2 | Negative input channel index (differential) |
| neg_com_o | output | 1 | Negative input tied to common |
| sleep_o | output | 1 | Power-down mode active |

## Verification
The checker runs on every cycle. It checks that the data output, the track line and the strobe's falling edge move only after a serial falling edge or a select rise. It also checks that track and strobe never overlap, that the sleep flag sets and clears on the correct serial edges with the strobe low, and that the data output is released while select is high. The bench scenarios cover everything that needs the whole frame: the decoded result for each channel, polarity and mode, the exact edge positions of track and strobe, the internal conversion length, the leading-zero hunt, and recovery after an abandoned frame.

// File: rtl/sar_front_pkg.sv
package sar_front_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_CTRL, ST_EXT_STRB, ST_EXT_CONV, ST_INT_CONV, ST_INT_RDY
  } fe_state_e;

  typedef enum logic [1:0] {
    PD_DEEP = 2'b00, PD_LIGHT = 2'b01, PD_INT = 2'b10, PD_EXT = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/sar_front_sync.sv
module sar_front_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sar_front_sar.sv
module sar_front_sar #(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] level_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o,
  output logic [RES_W-1:0] acc_o
);
  logic [RES_W-1:0] held_q, acc_q, trial;

  // trial code: bits already decided plus the bit under test
  assign trial = acc_q | (RES_W'(1) << idx_i);
  assign bit_o = (held_q >= trial);
  assign acc_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      held_q <= level_i;
      acc_q  <= '0;
    end else if (step_i) begin
      acc_q[idx_i] <= bit_o;
    end
  end
endmodule

// File: rtl/sar_serial_front.sv
module sar_serial_front import sar_front_pkg::*; #(
  parameter int RES_W       = 12,
  parameter int CYC_PER_BIT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             strb_o,
  output logic             strb_oe_o,
  output logic             track_o,
  output logic [1:0]       mux_pos_o,
  output logic [1:0]       mux_neg_o,
  output logic             neg_com_o,
  output logic             sleep_o
);
  localparam int CTRL_W   = 8;
  localparam int CNT_W    = $clog2(CTRL_W + 1);
  localparam int IDX_W    = $clog2(RES_W);
  localparam int TMR_W    = $clog2(CYC_PER_BIT + 1);
  localparam int TRACK_AT = CTRL_W - 3;
  localparam int MUX_AT   = CTRL_W - 2;

  logic [2:0] pins_s;
  logic       cs_hi, sclk_s, sdi_s, sclk_prev, cs_prev;
  logic       sck_r, sck_f, cs_rise, hold_ev, sar_step, sar_bit;
  logic [RES_W-1:0] level, sar_acc;

  fe_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              sdo_q, strb_q, track_q, sleep_q, neg_com_q;
  logic [1:0]        mux_pos_q, mux_neg_q;

  sar_front_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  assign cs_hi  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_hi;
    end
  end

  assign sck_r   = sclk_s & ~sclk_prev & ~cs_hi;
  assign sck_f   = ~sclk_s & sclk_prev & ~cs_hi;
  assign cs_rise = cs_hi & ~cs_prev;
  assign hold_ev = (state_q == ST_CTRL) && sck_f && (cnt_q == CNT_W'(CTRL_W))
                   && shreg_q[CTRL_W-1];
  // bipolar: offset level to two's complement by MSB inversion
  assign level   = shreg_q[3] ? sample_i
                              : {~sample_i[RES_W-1], sample_i[RES_W-2:0]};
  assign sar_step = (((state_q == ST_EXT_STRB) || (state_q == ST_EXT_CONV)) && sck_f)
                  || ((state_q == ST_INT_CONV) && (tmr_q == TMR_W'(CYC_PER_BIT - 1)));

  sar_front_sar #(.RES_W(RES_W)) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hold_ev),
    .level_i(level),
    .step_i (sar_step),
    .idx_i  (idx_q),
    .bit_o  (sar_bit),
    .acc_o  (sar_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      cnt_q     <= '0;
      shreg_q   <= '0;
      idx_q     <= '0;
      tmr_q     <= '0;
      sdo_q     <= 1'b0;
      strb_q    <= 1'b0;
      track_q   <= 1'b0;
      sleep_q   <= 1'b0;
      neg_com_q <= 1'b0;
      mux_pos_q <= '0;
      mux_neg_q <= '0;
    end else if (cs_rise && (state_q != ST_INT_CONV) && (state_q != ST_INT_RDY)) begin
      state_q <= ST_HUNT;
      track_q <= 1'b0;
      strb_q  <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (sck_f) sdo_q <= 1'b0;
          if (sck_r && sdi_s) begin
            state_q <= ST_CTRL;
            cnt_q   <= CNT_W'(1);
            shreg_q <= CTRL_W'(1);
            sleep_q <= 1'b0;
          end
        end
        ST_CTRL: begin
          if (sck_r) begin
            shreg_q <= {shreg_q[CTRL_W-2:0], sdi_s};
            cnt_q   <= cnt_q + 1'b1;
          end
          if (sck_f) begin
            sdo_q <= 1'b0;
            if (cnt_q == CNT_W'(TRACK_AT)) track_q <= 1'b1;
            if (cnt_q == CNT_W'(MUX_AT)) begin
              mux_pos_q <= {shreg_q[3], shreg_q[4]};
              neg_com_q <= shreg_q[0];
              mux_neg_q <= shreg_q[0] ? 2'b00 : {shreg_q[3], ~shreg_q[4]};
            end
          end
          if (hold_ev) begin
            track_q <= 1'b0;
            idx_q   <= IDX_W'(RES_W - 1);
            tmr_q   <= '0;
            unique case (pd_mode_e'(shreg_q[1:0]))
              PD_EXT: begin state_q <= ST_EXT_STRB; strb_q <= 1'b1; end
              PD_INT: begin state_q <= ST_INT_CONV; strb_q <= 1'b0; end
              default: begin state_q <= ST_HUNT; sleep_q <= 1'b1; end
            endcase
          end
        end
        ST_EXT_STRB: begin
          if (sck_f) begin
            sdo_q   <= sar_bit;
            strb_q  <= 1'b0;
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_EXT_CONV;
          end
        end
        ST_EXT_CONV: begin
          if (sck_f) begin
            sdo_q <= sar_bit;
            if (idx_q == '0) state_q <= ST_HUNT;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        ST_INT_CONV: begin
          if (tmr_q == TMR_W'(CYC_PER_BIT - 1)) begin
            tmr_q <= '0;
            if (idx_q == '0) begin
              state_q <= ST_INT_RDY;
              strb_q  <= 1'b1;
              idx_q   <= IDX_W'(RES_W - 1);
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_INT_RDY: begin
          if (sck_f) begin
            sdo_q <= sar_acc[idx_q];
            if (idx_q == '0) begin
              state_q <= ST_HUNT;
              strb_q  <= 1'b0;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = ~cs_hi;
  assign strb_o    = strb_q;
  assign strb_oe_o = ~cs_hi | (state_q == ST_INT_CONV) | (state_q == ST_INT_RDY);
  assign track_o   = track_q;
  assign mux_pos_o = mux_pos_q;
  assign mux_neg_o = mux_neg_q;
  assign neg_com_o = neg_com_q;
  assign sleep_o   = sleep_q;
endmodule

// File: rtl/sar_serial_front_chk.sv
module sar_serial_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic strb_o,
  input logic track_o,
  input logic sleep_o,
  input logic sck_r_i,
  input logic sck_f_i,
  input logic cs_rise_i
);
  p_sdo_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(sck_f_i) || $past(cs_rise_i)));

  p_track_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(track_o) |-> ($past(sck_f_i) || $past(cs_rise_i)));

  p_track_strb_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_o |-> !strb_o);

  p_strb_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_o) |-> ($past(sck_f_i) || $past(cs_rise_i)));

  p_sleep_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(sck_f_i));

  p_sleep_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> $past(sck_r_i));

  p_sleep_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !strb_o);

  // select high for four edges covers the default two-stage synchronizer
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_oe_o);
endmodule

bind sar_serial_front sar_serial_front_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .strb_o   (strb_o),
  .track_o  (track_o),
  .sleep_o  (sleep_o),
  .sck_r_i  (sck_r),
  .sck_f_i  (sck_f),
  .cs_rise_i(cs_rise)
);

// File: tb/sar_serial_front_tb.sv
`timescale 1ns/1ps
module sar_serial_front_tb;
  localparam int RES_W = 12;
  localparam int CYC   = 4;
  localparam int HALF  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0;
  logic [RES_W-1:0] sample_i = '0;
  logic sdo_o, sdo_oe_o, strb_o, strb_oe_o, track_o, neg_com_o, sleep_o;
  logic [1:0] mux_pos_o, mux_neg_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic lo_strb, lo_track;

  always #2.5 clk_i = ~clk_i;

  sar_serial_front #(.RES_W(RES_W), .CYC_PER_BIT(CYC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sample_i(sample_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .strb_o(strb_o),
    .strb_oe_o(strb_oe_o), .track_o(track_o), .mux_pos_o(mux_pos_o),
    .mux_neg_o(mux_neg_o), .neg_com_o(neg_com_o), .sleep_o(sleep_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // one serial bit: value before the rise and before the fall are returned
  task automatic clk_bit(input logic b, output logic so_lo, output logic so_hi);
    @(posedge clk_i); #1 sdi_i = b;
    repeat (HALF - 1) @(posedge clk_i);
    #1 so_lo = sdo_o; lo_strb = strb_o; lo_track = track_o; sclk_i = 1'b1;
    repeat (HALF) @(posedge clk_i);
    #1 so_hi = sdo_o; sclk_i = 1'b0;
  endtask

  task automatic run_ext(input logic [11:0] smp, input logic [2:0] sel,
                         input logic uni, input logic sgl, input int lead);
    logic [7:0] cb;
    logic [11:0] res, exp;
    logic lo, hi, tr5, tr6, tr9, st9, st10, tail, edge_bad;
    sample_i = smp;
    cb = {1'b1, sel, uni, sgl, 2'b11};
    res = '0; tail = 1'b0; edge_bad = 1'b0;
    tr5 = 0; tr6 = 0; tr9 = 0; st9 = 0; st10 = 0;
    cs_ni = 1'b0; cyc(HALF);
    for (int k = 0; k < lead; k++) clk_bit(1'b0, lo, hi);
    for (int j = 1; j <= 24; j++) begin
      clk_bit((j <= 8) ? cb[8-j] : 1'b0, lo, hi);
      if (j == 5) tr5 = lo_track;
      if (j == 6) tr6 = lo_track;
      if (j == 9) begin tr9 = lo_track; st9 = lo_strb; end
      if (j == 10) st10 = lo_strb;
      if (j >= 10 && j <= 21) res[21-j] = lo;
      if (j >= 22) tail |= lo;
      if (lo !== hi) edge_bad = 1'b1;
    end
    cs_ni = 1'b1; cyc(HALF);
    exp = uni ? smp : (smp ^ 12'h800);
    chk(res == exp, uni ? "R6 ext result" : "R7 bipolar result", res, exp);
    if (lead > 0) chk(res == exp, "R1 leading zeros", res, exp);
    chk(!tr5 && tr6 && !tr9, "R3 track window", {tr5, tr6, tr9}, 3'b010);
    chk(st9 && !st10, "R6 strobe pulse", {st9, st10}, 2'b10);
    chk(!tail, "R6 zero tail", tail, 0);
    chk(!edge_bad, "R2 sdo steady on rise", edge_bad, 0);
    chk(mux_pos_o == {sel[1], sel[2]}, "R4 positive channel", mux_pos_o, {sel[1], sel[2]});
    chk(neg_com_o == sgl && mux_neg_o == (sgl ? 2'b00 : {sel[1], ~sel[2]}),
        "R4 negative channel", {neg_com_o, mux_neg_o},
        {sgl, (sgl ? 2'b00 : {sel[1], ~sel[2]})});
    chk(!sleep_o, "R5 awake after start", sleep_o, 0);
  endtask

  task automatic run_int(input logic [11:0] smp, input logic uni, input bit raise);
    logic [7:0] cb;
    logic [11:0] res, exp;
    logic lo, hi, tail, st1;
    int t;
    sample_i = smp;
    cb = {1'b1, 3'b001, uni, 1'b1, 2'b10};
    res = '0; tail = 1'b0; st1 = 1'b0;
    cs_ni = 1'b0; cyc(HALF);
    for (int j = 1; j <= 8; j++) clk_bit(cb[8-j], lo, hi);
    cyc(6); t = 6;
    chk(!strb_o, "R8 strobe low in conversion", strb_o, 0);
    if (raise) begin
      cs_ni = 1'b1; cyc(6); t += 6;
      chk(strb_oe_o && !sdo_oe_o, "R9 strobe driven during internal conversion",
          {strb_oe_o, sdo_oe_o}, 2'b10);
    end
    while (!strb_o && t < 400) begin cyc(1); t++; end
    chk(t >= RES_W * CYC && t <= RES_W * CYC + 8, "R8 conversion length", t, RES_W * CYC);
    if (raise) begin cs_ni = 1'b0; cyc(HALF); end
    for (int j = 1; j <= 16; j++) begin
      clk_bit(1'b0, lo, hi);
      if (j == 1) st1 = lo_strb;
      if (j >= 2 && j <= 13) res[13-j] = lo;
      else tail |= lo;
    end
    cs_ni = 1'b1; cyc(HALF);
    exp = uni ? smp : (smp ^ 12'h800);
    chk(res == exp, raise ? "R8 result after select rise" : "R8 internal result", res, exp);
    if (!uni) chk(res == exp, "R7 internal bipolar", res, exp);
    chk(st1, "R8 strobe high before readout", st1, 1);
    chk(!tail, "R8 quiet outside result", tail, 0);
  endtask

  task automatic run_pd(input logic [1:0] pd);
    logic [7:0] cb;
    logic lo, hi, busy;
    cb = {1'b1, 3'b010, 1'b1, 1'b1, pd};
    busy = 1'b0;
    cs_ni = 1'b0; cyc(HALF);
    for (int j = 1; j <= 16; j++) begin
      clk_bit((j <= 8) ? cb[8-j] : 1'b0, lo, hi);
      if (j >= 9) busy |= lo | lo_strb;
    end
    chk(sleep_o, "R5 sleep flag set", sleep_o, 1);
    chk(!busy, "R5 no conversion in power-down", busy, 0);
    cs_ni = 1'b1; cyc(HALF);
  endtask

  function automatic logic [11:0] pick(input int i);
    case (i)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'hA5C;
    endcase
  endfunction

  initial begin
    logic lo, hi;
    cyc(4); rst_ni = 1'b1; cyc(4);
    chk(!sdo_oe_o && !strb_oe_o, "R9 released at reset", {sdo_oe_o, strb_oe_o}, 0);
    chk(!track_o && !strb_o && !sleep_o, "R3 reset idle", {track_o, strb_o, sleep_o}, 0);
    cs_ni = 1'b0; cyc(HALF);
    chk(sdo_oe_o && strb_oe_o && !strb_o, "R9 strobe low after select fall",
        {sdo_oe_o, strb_oe_o, strb_o}, 3'b110);
    cs_ni = 1'b1; cyc(HALF);

    for (int s = 0; s < 5; s++)
      for (int u = 0; u < 2; u++)
        for (int sel = 0; sel < 8; sel++)
          for (int g = 0; g < 2; g++)
            run_ext(pick(s) ^ 12'(sel * 37), 3'(sel), 1'(u), 1'(g), (sel % 3) * 3);

    run_int(12'h3C5, 1'b1, 1'b0);
    run_int(12'hC3A, 1'b0, 1'b0);
    run_int(12'h9E1, 1'b1, 1'b1);

    run_pd(2'b00);
    run_ext(12'h456, 3'b101, 1'b1, 1'b0, 2);
    run_pd(2'b01);
    run_ext(12'hB21, 3'b010, 1'b0, 1'b1, 0);

    // R10: abandon during control byte
    cs_ni = 1'b0; cyc(HALF);
    for (int j = 1; j <= 6; j++) clk_bit((j == 1) ? 1'b1 : 1'b0, lo, hi);
    cyc(6);
    chk(track_o, "R10 tracking before abort", track_o, 1);
    cs_ni = 1'b1; cyc(HALF);
    chk(!track_o, "R10 track cleared by abort", track_o, 0);
    run_ext(12'h5A3, 3'b110, 1'b1, 1'b0, 1);

    // R10: abandon during external readout
    cs_ni = 1'b0; cyc(HALF);
    for (int j = 1; j <= 14; j++) clk_bit((j == 1 || j >= 7) ? (j <= 8) : 1'b0, lo, hi);
    cs_ni = 1'b1; cyc(HALF);
    chk(!strb_o && !track_o, "R10 idle after readout abort", {strb_o, track_o}, 0);
    run_ext(12'h1F0, 3'b001, 1'b1, 1'b1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule